// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block decides, every cycle, whether an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) must leave its normal flow for a trap handler. Fetch, decode, execute and memory each report a fault flag, a cause code and the PC of the instruction they hold. Writeback never faults, because any instruction that gets that far always completes. When at least one stage reports a fault, the controller picks the oldest faulting instruction as the victim. It squashes that instruction and every younger one, and records the victim's PC and cause in two trap registers. It also tells fetch to restart at a fixed handler entry address.

Asynchronous interrupt requests are not tied to any instruction. The controller attaches them to the instruction in the memory stage, and that instruction is then squashed and recorded so that it is re-executed after the handler. If the memory slot holds a bubble, the request is kept pending until a valid instruction arrives there. A fault in the memory stage kills that stage's data-memory write and register write in the same cycle the fault is seen.

The decision path is combinational, so the squash controls reach the pipeline registers at the next clock edge. The trap registers load at that same edge.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, `trap_epc` and `trap_cause` are zero, no interrupt is pending, and `take` and `squash` are zero while all inputs are zero.
- R2: When exactly one stage faults, `take` is 1 in the same cycle. `squash[j]` is 1 for every stage index j at or below that stage's index and 0 for every index above it. Index 0 is fetch, 1 is decode, 2 is execute and 3 is memory.
- R3: When several stages fault in the same cycle, the stage with the highest index (the oldest instruction) is the victim. Squashing follows R2 for that index, and the faults of the other stages are discarded.
- R4: At the clock edge where `take` is 1, `trap_epc` and `trap_cause` load the victim's PC and cause. In any other cycle they hold their value.
- R5: Whenever `take` is 1, `redirect_pc` is 32'h8000_0180.
- R6: An interrupt request, with a valid memory-stage instruction and no memory-stage fault, is taken in that cycle. The victim is the memory-stage instruction, `squash` is all ones, and the recorded cause is 0.
- R7: An interrupt request that arrives while the memory slot holds a bubble causes no `take` and stays pending. It is taken, with cause 0 and the memory-stage PC, in the first later cycle that has a valid memory-stage instruction.
- R8: If the memory stage faults in the same cycle as an interrupt request, the memory fault is taken and the interrupt stays pending for a later cycle.
- R9: An interrupt that is taken (R6) wins over faults in fetch, decode or execute in the same cycle.
- R10: A memory-stage fault drives `squash[3]` to 1 in the same cycle, which suppresses that instruction's memory write and register write.
- R11: With no fault flags, no interrupt request and nothing pending, `take` and `squash` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_exc | input | NSTG (4) | Fault flag per stage; bit 0 fetch, bit 3 memory |
| stage_cause | input | NSTG*CW (20) | Cause code per stage; slice i is bits [i*CW +: CW] |
| stage_pc | input | NSTG*XLEN (128) | Instruction PC per stage; slice i is bits [i*XLEN +: XLEN] |
| mem_valid | input | 1 | The memory stage holds a valid instruction |
| irq_req | input | 1 | Asynchronous interrupt request |
| take | output | 1 | A trap is taken this cycle; fetch redirects |
| squash | output | NSTG (4) | Bit i kills stage i; bits 0 to 2 flush the fetch/decode, decode/execute and execute/memory boundaries, bit 3 suppresses memory-stage writes |
| redirect_pc | output | XLEN (32) | Handler entry address for fetch |
| trap_epc | output | XLEN (32) | PC of the last victim |
| trap_cause | output | CW (5) | Cause code of the last victim |

## Verification
On every cycle, the assertions check three things. The squash vector is always a contiguous run of ones starting at fetch. A memory-stage fault always kills that stage, and an idle cycle never squashes anything. The trap registers change only after a `take`, and a pending interrupt that is not taken stays pending.

Only the bench scenarios show the rest. They confirm that the right victim is chosen among simultaneous faults and interrupts, that the recorded PC and cause are correct, and that an interrupt deferred by a bubble or by a memory fault is taken later with the memory-stage PC.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned NSTG_DEF = 4;
  localparam int unsigned XLEN_DEF = 32;
  localparam int unsigned CW_DEF   = 5;
  typedef enum logic [1:0] {
    STG_FETCH  = 2'd0,
    STG_DECODE = 2'd1,
    STG_EXEC   = 2'd2,
    STG_MEMORY = 2'd3
  } stage_e;
endpackage

// File: rtl/exc_prio.sv
module exc_prio #(
  parameter int unsigned NSTG      = 4,
  parameter int unsigned XLEN      = 32,
  parameter int unsigned CW        = 5,
  parameter logic [CW-1:0] IRQ_CAUSE = '0
) (
  input  logic [NSTG-1:0]      flag,
  input  logic [NSTG*CW-1:0]   cause_flat,
  input  logic [NSTG*XLEN-1:0] pc_flat,
  input  logic                 irq_fire,
  output logic                 take,
  output logic [XLEN-1:0]      sel_pc,
  output logic [CW-1:0]        sel_cause,
  output logic [NSTG-1:0]      kill
);
  localparam int unsigned SW = (NSTG > 1) ? $clog2(NSTG) : 1;
  localparam logic [SW-1:0] OLDEST = SW'(NSTG - 1);

  logic [SW-1:0] vic;

  // Scan from youngest to oldest so the oldest faulting stage overrides.
  always_comb begin
    take      = 1'b0;
    vic       = '0;
    sel_pc    = '0;
    sel_cause = '0;
    for (int i = 0; i < int'(NSTG); i++) begin
      if (flag[i]) begin
        take      = 1'b1;
        vic       = SW'(i);
        sel_pc    = pc_flat[i*XLEN +: XLEN];
        sel_cause = cause_flat[i*CW +: CW];
      end
    end
    if (irq_fire) begin
      take      = 1'b1;
      vic       = OLDEST;
      sel_pc    = pc_flat[(NSTG-1)*XLEN +: XLEN];
      sel_cause = IRQ_CAUSE;
    end
  end

  for (genvar j = 0; j < NSTG; j++) begin : g_kill
    localparam logic [SW-1:0] JIDX = SW'(j);
    assign kill[j] = take && (JIDX <= vic);
  end
endmodule

// File: rtl/exc_irq.sv
module exc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic mem_valid,
  input  logic mem_fault,
  output logic fire,
  output logic pend
);
  logic pend_n;
  logic active;

  assign active = irq_req || pend;
  assign fire   = active && mem_valid && !mem_fault;

  always_comb begin
    pend_n = active && !fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_n;
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !mem_valid) |=> pend); // R7
endmodule

// File: rtl/exc_trap_regs.sv
module exc_trap_regs #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned CW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [XLEN-1:0] pc_in,
  input  logic [CW-1:0]   cause_in,
  output logic [XLEN-1:0] epc,
  output logic [CW-1:0]   cause
);
  logic [XLEN-1:0] epc_n;
  logic [CW-1:0]   cause_n;

  always_comb begin
    epc_n   = epc;
    cause_n = cause;
    if (load) begin
      epc_n   = pc_in;
      cause_n = cause_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= '0;
    end else begin
      epc   <= epc_n;
      cause <= cause_n;
    end
  end

  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(epc) && $stable(cause))); // R4
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter int unsigned NSTG = exc_pkg::NSTG_DEF,
  parameter int unsigned XLEN = exc_pkg::XLEN_DEF,
  parameter int unsigned CW   = exc_pkg::CW_DEF,
  parameter logic [XLEN-1:0] HANDLER_PC = XLEN'(32'h8000_0180),
  parameter logic [CW-1:0]   IRQ_CAUSE  = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSTG-1:0]      stage_exc,
  input  logic [NSTG*CW-1:0]   stage_cause,
  input  logic [NSTG*XLEN-1:0] stage_pc,
  input  logic                 mem_valid,
  input  logic                 irq_req,
  output logic                 take,
  output logic [NSTG-1:0]      squash,
  output logic [XLEN-1:0]      redirect_pc,
  output logic [XLEN-1:0]      trap_epc,
  output logic [CW-1:0]        trap_cause
);
  logic            irq_fire;
  logic            irq_pend;
  logic [XLEN-1:0] vic_pc;
  logic [CW-1:0]   vic_cause;

  exc_irq i_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .mem_valid (mem_valid),
    .mem_fault (stage_exc[NSTG-1]),
    .fire      (irq_fire),
    .pend      (irq_pend)
  );

  exc_prio #(.NSTG(NSTG), .XLEN(XLEN), .CW(CW), .IRQ_CAUSE(IRQ_CAUSE)) i_prio (
    .flag       (stage_exc),
    .cause_flat (stage_cause),
    .pc_flat    (stage_pc),
    .irq_fire   (irq_fire),
    .take       (take),
    .sel_pc     (vic_pc),
    .sel_cause  (vic_cause),
    .kill       (squash)
  );

  exc_trap_regs #(.XLEN(XLEN), .CW(CW)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .pc_in    (vic_pc),
    .cause_in (vic_cause),
    .epc      (trap_epc),
    .cause    (trap_cause)
  );

  assign redirect_pc = HANDLER_PC;

  for (genvar j = 1; j < NSTG; j++) begin : g_chk
    AST_SQUASH_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      squash[j] |-> squash[j-1]); // R2
  end

  AST_VICTIM_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> squash[0]); // R2
  AST_MEM_FAULT_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    stage_exc[NSTG-1] |-> (take && squash[NSTG-1])); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_exc == '0 && !irq_req && !irq_pend) |-> (!take && squash == '0)); // R11
endmodule

// File: tb/test_exc_ctrl.sv
module test_exc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSTG = 4;
  localparam int XLEN = 32;
  localparam int CW   = 5;

  logic                 clk;
  logic                 rst_n;
  logic [NSTG-1:0]      stage_exc;
  logic [NSTG*CW-1:0]   stage_cause;
  logic [NSTG*XLEN-1:0] stage_pc;
  logic                 mem_valid;
  logic                 irq_req;
  logic                 take;
  logic [NSTG-1:0]      squash;
  logic [XLEN-1:0]      redirect_pc;
  logic [XLEN-1:0]      trap_epc;
  logic [CW-1:0]        trap_cause;

  int checks;
  int errors;

  exc_ctrl i_exc_ctrl (
    .clk(clk), .rst_n(rst_n), .stage_exc(stage_exc), .stage_cause(stage_cause),
    .stage_pc(stage_pc), .mem_valid(mem_valid), .irq_req(irq_req), .take(take),
    .squash(squash), .redirect_pc(redirect_pc), .trap_epc(trap_epc),
    .trap_cause(trap_cause)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] m_epc;
    logic [4:0]  m_cause;
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    stage_exc = '0; stage_cause = '0; stage_pc = '0; mem_valid = 1'b0; irq_req = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(trap_epc == 0, "R1 epc", trap_epc, 0);
    check(trap_cause == 0, "R1 cause", 32'(trap_cause), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!take && squash == 0, "R1 idle", {27'd0, take, squash}, 0);
    m_epc = 0;
    m_cause = 0;

    for (int c = 0; c < 64; c++) begin
      logic [3:0]  ex;
      logic        irq, mv, fire, exp_take, pend;
      int          vic;
      logic [3:0]  exp_sq;
      logic [31:0] vpc;
      logic [4:0]  vcause;
      string       tag;
      ex  = c[3:0];
      irq = c[4];
      mv  = c[5];
      @(negedge clk);
      stage_exc = ex;
      mem_valid = mv;
      irq_req   = irq;
      for (int s = 0; s < NSTG; s++) begin
        stage_pc[s*XLEN +: XLEN]  = 32'h1000 + 32'(c*16) + 32'(s*4);
        stage_cause[s*CW +: CW]   = 5'(s + 1 + 4*(c % 4));
      end
      // bench model
      fire = irq && mv && !ex[3];
      vic = -1;
      for (int s = 0; s < NSTG; s++) if (ex[s]) vic = s;
      if (fire) vic = 3;
      exp_take = (vic >= 0);
      exp_sq = 0;
      for (int s = 0; s < NSTG; s++) if (exp_take && s <= vic) exp_sq[s] = 1'b1;
      vpc = 0;
      vcause = 0;
      if (exp_take) begin
        vpc = 32'h1000 + 32'(c*16) + 32'(vic*4);
        vcause = fire ? 5'd0 : 5'(vic + 1 + 4*(c % 4));
      end
      pend = irq && !fire;
      if (fire && ex[2:0] != 0)         tag = "R9";
      else if (fire)                    tag = "R6";
      else if (irq && ex[3] && mv)      tag = "R8";
      else if ($countones(ex) > 1)      tag = "R3";
      else if (ex != 0)                 tag = "R2";
      else if (irq)                     tag = "R7";
      else                              tag = "R11";
      #1;
      check(take == exp_take, {tag, " take"}, 32'(take), 32'(exp_take));
      check(squash == exp_sq, {tag, " squash"}, 32'(squash), 32'(exp_sq));
      if (ex[3]) check(squash[3], "R10 mem kill", 32'(squash[3]), 1);
      if (exp_take) check(redirect_pc == 32'h8000_0180, "R5 redirect", redirect_pc, 32'h8000_0180);
      @(posedge clk);
      #1;
      if (exp_take) begin
        m_epc = vpc;
        m_cause = vcause;
      end
      check(trap_epc == m_epc, "R4 epc", trap_epc, m_epc);
      check(trap_cause == m_cause, "R4 cause", 32'(trap_cause), 32'(m_cause));

      // drain cycle: no faults, valid memory slot, no new request
      @(negedge clk);
      stage_exc = '0;
      irq_req   = 1'b0;
      mem_valid = 1'b1;
      stage_pc[3*XLEN +: XLEN] = 32'h9000 + 32'(c*4);
      #1;
      check(take == pend, pend ? "R7 pending take" : "R11 drain idle", 32'(take), 32'(pend));
      @(posedge clk);
      #1;
      if (pend) begin
        m_epc = 32'h9000 + 32'(c*4);
        m_cause = 5'd0;
      end
      check(trap_epc == m_epc, pend ? "R7 epc" : "R4 hold epc", trap_epc, m_epc);
      check(trap_cause == m_cause, pend ? "R7 cause" : "R4 hold cause",
            32'(trap_cause), 32'(m_cause));
      @(negedge clk);
      mem_valid = 1'b0;
    end

    // long bubble run: interrupt stays pending across several empty cycles
    @(negedge clk);
    irq_req = 1'b1;
    mem_valid = 1'b0;
    #1;
    check(!take, "R7 bubble no take", 32'(take), 0);
    @(negedge clk);
    irq_req = 1'b0;
    repeat (4) begin
      #1;
      check(!take, "R7 held no take", 32'(take), 0);
      @(negedge clk);
    end
    mem_valid = 1'b1;
    stage_pc[3*XLEN +: XLEN] = 32'hABC0;
    #1;
    check(take && squash == 4'hF, "R7 late take", {27'd0, take, squash}, 32'h1F);
    @(posedge clk);
    #1;
    check(trap_epc == 32'hABC0 && trap_cause == 0, "R7 late epc", trap_epc, 32'hABC0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule